// File: doc/BRIEF.md
# Byte-Serial Order Message Parser

This block sits behind a UDP payload extractor and turns a stream of exchange market-data messages into normalized order-book commands. The payload arrives one byte per clock, qualified by a valid flag. The block drives an input-ready signal back to the source. Each message starts with a length byte that counts the whole message, including the length byte itself. The type byte follows it and selects how the remaining bytes are decoded.

Four formats are recognized: a long add-order, a short add-order, an execute and a cancel. Fields of different widths in the different formats are widened into one fixed record. That record is presented in a single cycle on a ready/valid output. Messages of any other type are skipped by their length and produce nothing. While a finished command waits for the consumer, input is held off, so no byte is lost and no command is overwritten.

Top module: `mdp_parser`

## Requirements
- R1: A synchronous reset clears `cmd_valid` and sets `in_ready` on the next clock. Parsing then restarts at message offset 0, even if the reset arrived in the middle of a message.
- R2: Offset 0 of every message is its total length in bytes, including the length byte. The next message begins right after that many accepted bytes. A length byte of 0 or 1 forms a one-byte message with no command.
- R3: Offset 1 is the type: 0x21 is long add, 0x22 is short add, 0x23 is execute and 0x24 is cancel. Any other type is consumed by its length and emits no command. `cmd_code` is 1 for add, 2 for execute and 3 for cancel, and is never 0 while `cmd_valid` is high.
- R4: Long add (length 33) carries the order id (8 bytes) at offset 6 and the side byte at offset 14. Quantity (4 bytes) is at offset 15, the symbol (6 characters) at 19 and the price (8 bytes) at 25. Bytes 2 to 5 are ignored. The side byte is passed through as ASCII: 0x42 is buy and 0x53 is sell.
- R5: Short add (length 27) carries the order id at offset 6 and the side at 14. Quantity is 2 bytes at 15, the symbol is at 17 and the price is 4 bytes at 23. Quantity and price are zero-extended to 32 and 64 bits.
- R6: Execute (length 18) carries the order id at offset 6 and the executed quantity (4 bytes) at 14. Quantity, cancelled quantity, price and side are output as 0.
- R7: Cancel (length 18) carries the order id at offset 6 and the cancelled quantity (4 bytes) at 14. Quantity, executed quantity, price and side are output as 0.
- R8: Every multi-byte numeric field is little-endian: the byte received first is the least significant.
- R9: `cmd_symbol` is 8 ASCII bytes. The first received character is in bits 63:56, and each later character sits one byte lower. Bits 15:0 are always 0x2020 (space padding), and the symbol is all spaces for execute and cancel.
- R10: `cmd_valid` rises on the clock that accepts the last byte of a recognized message. It stays high for exactly one cycle when `cmd_ready` is high. While `cmd_ready` is low it stays high with every field unchanged.
- R11: `in_ready` is low exactly when `cmd_valid` is high and `cmd_ready` is low. No byte is accepted in that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte is valid |
| in_ready | output | 1 | Block accepts a byte this cycle |
| cmd_ready | input | 1 | Consumer takes the command this cycle |
| cmd_valid | output | 1 | Normalized command present |
| cmd_code | output | 2 | 1 add, 2 execute, 3 cancel |
| cmd_side | output | 8 | ASCII side, 0 when not applicable |
| cmd_qty | output | 32 | Order quantity |
| cmd_exec_qty | output | 32 | Executed quantity |
| cmd_cancel_qty | output | 32 | Cancelled quantity |
| cmd_price | output | 64 | Price |
| cmd_symbol | output | 64 | Space-padded ASCII symbol |
| cmd_order_id | output | 64 | Order id |

## Verification
The assertions check the following on every cycle:
- the input back-pressure rule;
- field stability while a command is held;
- that a command appears only right after an accepted byte;
- the non-zero command code;
- the symbol padding;
- that unused fields are zero for execute and cancel.

Only the bench scenarios can show the rest:
- that the framing tracks the length byte;
- the offset and byte-order decoding of each format;
- the zero extension of short fields;
- the silent skipping of unknown types and one-byte messages;
- recovery from a reset in the middle of a message.

The bench runs these scenarios under idle gaps and consumer stalls and compares against a behavioural model.

// File: rtl/mdp_pkg.sv
package mdp_pkg;
  localparam int SYM_CHARS = 6;
  localparam int SYM_BYTES = 8;
  localparam int ID_OFS    = 6;
  localparam int SIDE_OFS  = 14;
  localparam int QTY_OFS   = 15;
  localparam int LONG_SYM  = 19;
  localparam int LONG_PX   = 25;
  localparam int SHORT_SYM = 17;
  localparam int SHORT_PX  = 23;
  localparam int EVT_QTY   = 14;

  localparam logic [7:0] T_ADD_LONG  = 8'h21;
  localparam logic [7:0] T_ADD_SHORT = 8'h22;
  localparam logic [7:0] T_EXEC      = 8'h23;
  localparam logic [7:0] T_CANCEL    = 8'h24;

  typedef enum logic [1:0] {
    CMD_NONE = 2'd0, CMD_ADD = 2'd1, CMD_EXEC = 2'd2, CMD_CANCEL = 2'd3
  } cmd_e;

  typedef struct packed {
    cmd_e        code;
    logic [7:0]  side;
    logic [31:0] qty;
    logic [31:0] exec_qty;
    logic [31:0] cancel_qty;
    logic [63:0] price;
    logic [63:0] symbol;
    logic [63:0] order_id;
  } cmd_rec_t;

  function automatic cmd_rec_t blank_rec();
    cmd_rec_t r;
    r = '0;
    r.code   = CMD_NONE;
    r.symbol = {SYM_BYTES{8'h20}};
    return r;
  endfunction

  function automatic logic [63:0] le_put64(input logic [63:0] cur, input logic [7:0] off,
                                           input int base, input int nbytes, input logic [7:0] b);
    logic [63:0] r;
    r = cur;
    for (int i = 0; i < 8; i++)
      if (i < nbytes && int'(off) == base + i) r[8*i +: 8] = b;
    return r;
  endfunction

  function automatic logic [31:0] le_put32(input logic [31:0] cur, input logic [7:0] off,
                                           input int base, input int nbytes, input logic [7:0] b);
    logic [31:0] r;
    r = cur;
    for (int i = 0; i < 4; i++)
      if (i < nbytes && int'(off) == base + i) r[8*i +: 8] = b;
    return r;
  endfunction

  function automatic logic [63:0] sym_put(input logic [63:0] cur, input logic [7:0] off,
                                          input int base, input logic [7:0] b);
    logic [63:0] r;
    r = cur;
    for (int k = 0; k < SYM_CHARS; k++)
      if (int'(off) == base + k) r[8*(SYM_BYTES-1-k) +: 8] = b;
    return r;
  endfunction

  function automatic logic type_known(input logic [7:0] t);
    return (t == T_ADD_LONG) || (t == T_ADD_SHORT) || (t == T_EXEC) || (t == T_CANCEL);
  endfunction

  function automatic cmd_rec_t apply_byte(input cmd_rec_t rec, input logic [7:0] mtype,
                                          input logic [7:0] off, input logic [7:0] b);
    cmd_rec_t r;
    r = rec;
    case (mtype)
      T_ADD_LONG, T_ADD_SHORT: begin
        if (off == 8'd1) r.code = CMD_ADD;
        r.order_id = le_put64(r.order_id, off, ID_OFS, 8, b);
        if (int'(off) == SIDE_OFS) r.side = b;
        if (mtype == T_ADD_LONG) begin
          r.qty    = le_put32(r.qty, off, QTY_OFS, 4, b);
          r.symbol = sym_put(r.symbol, off, LONG_SYM, b);
          r.price  = le_put64(r.price, off, LONG_PX, 8, b);
        end else begin
          r.qty    = le_put32(r.qty, off, QTY_OFS, 2, b);
          r.symbol = sym_put(r.symbol, off, SHORT_SYM, b);
          r.price  = le_put64(r.price, off, SHORT_PX, 4, b);
        end
      end
      T_EXEC: begin
        if (off == 8'd1) r.code = CMD_EXEC;
        r.order_id = le_put64(r.order_id, off, ID_OFS, 8, b);
        r.exec_qty = le_put32(r.exec_qty, off, EVT_QTY, 4, b);
      end
      T_CANCEL: begin
        if (off == 8'd1) r.code = CMD_CANCEL;
        r.order_id   = le_put64(r.order_id, off, ID_OFS, 8, b);
        r.cancel_qty = le_put32(r.cancel_qty, off, EVT_QTY, 4, b);
      end
      default: r = rec;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mdp_framer.sv
module mdp_framer (
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic [7:0] in_data,
  output logic [7:0] offset,
  output logic [7:0] cur_type,
  output logic       is_last
);
  logic [7:0] cnt_q, len_q, type_q;

  assign offset   = cnt_q;
  assign cur_type = (cnt_q == 8'd1) ? in_data : type_q;
  assign is_last  = (cnt_q == 8'd0) ? (in_data <= 8'd1) : (cnt_q == len_q - 8'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      len_q  <= '0;
      type_q <= '0;
    end else if (accept) begin
      cnt_q <= is_last ? 8'd0 : cnt_q + 8'd1;
      if (cnt_q == 8'd0) len_q  <= in_data;
      if (cnt_q == 8'd1) type_q <= in_data;
    end
  end
endmodule

// File: rtl/mdp_extract.sv
module mdp_extract
  import mdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       accept,
  input  logic [7:0] in_data,
  input  logic [7:0] offset,
  input  logic [7:0] cur_type,
  input  logic       is_last,
  output cmd_rec_t   rec_next,
  output logic       emit
);
  cmd_rec_t rec_q, rec_base;

  assign rec_base = (offset == 8'd0) ? blank_rec() : rec_q;
  assign rec_next = apply_byte(rec_base, cur_type, offset, in_data);
  assign emit     = accept && is_last && (offset != 8'd0) && type_known(cur_type);

  always_ff @(posedge clk) begin
    if (rst)         rec_q <= blank_rec();
    else if (accept) rec_q <= rec_next;
  end
endmodule

// File: rtl/mdp_cmd_hold.sv
module mdp_cmd_hold
  import mdp_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     emit,
  input  cmd_rec_t rec_in,
  input  logic     cmd_ready,
  output logic     cmd_valid,
  output cmd_rec_t rec_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      rec_out   <= blank_rec();
    end else if (emit) begin
      cmd_valid <= 1'b1;
      rec_out   <= rec_in;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mdp_parser.sv
module mdp_parser
  import mdp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic        cmd_ready,
  output logic        cmd_valid,
  output logic [1:0]  cmd_code,
  output logic [7:0]  cmd_side,
  output logic [31:0] cmd_qty,
  output logic [31:0] cmd_exec_qty,
  output logic [31:0] cmd_cancel_qty,
  output logic [63:0] cmd_price,
  output logic [63:0] cmd_symbol,
  output logic [63:0] cmd_order_id
);
  logic       accept, is_last, emit;
  logic [7:0] offset, cur_type;
  cmd_rec_t   rec_next, rec_out;

  assign in_ready = !(cmd_valid && !cmd_ready);
  assign accept   = in_valid && in_ready;

  mdp_framer u_framer (
    .clk(clk), .rst(rst), .accept(accept), .in_data(in_data),
    .offset(offset), .cur_type(cur_type), .is_last(is_last)
  );

  mdp_extract u_extract (
    .clk(clk), .rst(rst), .accept(accept), .in_data(in_data),
    .offset(offset), .cur_type(cur_type), .is_last(is_last),
    .rec_next(rec_next), .emit(emit)
  );

  mdp_cmd_hold u_hold (
    .clk(clk), .rst(rst), .emit(emit), .rec_in(rec_next),
    .cmd_ready(cmd_ready), .cmd_valid(cmd_valid), .rec_out(rec_out)
  );

  assign cmd_code       = rec_out.code;
  assign cmd_side       = rec_out.side;
  assign cmd_qty        = rec_out.qty;
  assign cmd_exec_qty   = rec_out.exec_qty;
  assign cmd_cancel_qty = rec_out.cancel_qty;
  assign cmd_price      = rec_out.price;
  assign cmd_symbol     = rec_out.symbol;
  assign cmd_order_id   = rec_out.order_id;
endmodule

// File: rtl/mdp_parser_chk.sv
module mdp_parser_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        cmd_ready,
  input logic        cmd_valid,
  input logic [1:0]  cmd_code,
  input logic [7:0]  cmd_side,
  input logic [31:0] cmd_qty,
  input logic [31:0] cmd_exec_qty,
  input logic [31:0] cmd_cancel_qty,
  input logic [63:0] cmd_price,
  input logic [63:0] cmd_symbol,
  input logic [63:0] cmd_order_id
);
  p_reset_idle_r1: assert property (@(posedge clk) rst |=> !cmd_valid);

  p_block_input_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |-> !in_ready);

  p_open_input_r11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |-> in_ready);

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_code) && $stable(cmd_side) &&
      $stable(cmd_qty) && $stable(cmd_price) && $stable(cmd_symbol) && $stable(cmd_order_id)));

  p_after_byte_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_valid) |-> $past(in_valid && in_ready));

  p_code_set_r3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_code != 2'd0));

  p_sym_pad_r9: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_symbol[15:0] == 16'h2020));

  p_exec_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 2'd2) |-> (cmd_qty == 0 && cmd_cancel_qty == 0 && cmd_side == 0));

  p_cancel_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == 2'd3) |-> (cmd_qty == 0 && cmd_exec_qty == 0 && cmd_side == 0));
endmodule

bind mdp_parser mdp_parser_chk u_chk (.*);

// File: tb/test_mdp_parser.sv
module test_mdp_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  in_data = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        cmd_ready = 1'b1;
  logic        cmd_valid;
  logic [1:0]  cmd_code;
  logic [7:0]  cmd_side;
  logic [31:0] cmd_qty, cmd_exec_qty, cmd_cancel_qty;
  logic [63:0] cmd_price, cmd_symbol, cmd_order_id;

  always #2.5 clk = ~clk;

  mdp_parser i_mdp_parser (.*);

  typedef struct {
    int          code;
    logic [7:0]  side;
    logic [31:0] qty, eq, cq;
    logic [63:0] px, sym, id;
    string       tag;
  } exp_t;

  logic [7:0] bq[$];
  bit         lastq[$];
  exp_t       eqq[$];
  int total = 0, fails = 0, cycles = 0;
  bit exp_valid = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] ex);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, ex);
    end
  endtask

  task automatic put(input logic [7:0] b, input bit last);
    bq.push_back(b); lastq.push_back(last);
  endtask

  task automatic put_le(input logic [63:0] v, input int n);
    for (int i = 0; i < n; i++) put(v[8*i +: 8], 0);
  endtask

  function automatic logic [63:0] sym_of(input string s);
    logic [63:0] r = {8{8'h20}};
    for (int k = 0; k < 6; k++) r[63-8*k -: 8] = s[k];
    return r;
  endfunction

  task automatic head(input logic [7:0] len, input logic [7:0] t);
    put(len, 0); put(t, 0); put_le(64'hDEADBEEF, 4);
  endtask

  // R4 / R5 build add messages; R8 little-endian packing
  task automatic add_msg(input bit lng, input logic [63:0] id, input logic [7:0] side,
                         input logic [31:0] q, input string s, input logic [63:0] px);
    exp_t e;
    head(lng ? 8'd33 : 8'd27, lng ? 8'h21 : 8'h22);
    put_le(id, 8); put(side, 0); put_le(q, lng ? 4 : 2);
    for (int k = 0; k < 6; k++) put(s[k], 0);
    put_le(px, lng ? 7 : 3);
    put(lng ? px[63:56] : px[31:24], 1);
    e.code = 1; e.side = side; e.eq = 0; e.cq = 0; e.id = id; e.sym = sym_of(s);
    e.qty = lng ? q : {16'h0, q[15:0]};
    e.px  = lng ? px : {32'h0, px[31:0]};
    e.tag = lng ? "R4" : "R5";
    eqq.push_back(e);
  endtask

  // R6 / R7 event messages
  task automatic evt_msg(input bit ex, input logic [63:0] id, input logic [31:0] q);
    exp_t e;
    head(8'd18, ex ? 8'h23 : 8'h24);
    put_le(id, 8); put_le(q, 3); put(q[31:24], 1);
    e.code = ex ? 2 : 3; e.side = 0; e.qty = 0; e.px = 0; e.id = id;
    e.eq = ex ? q : 0; e.cq = ex ? 0 : q; e.sym = {8{8'h20}};
    e.tag = ex ? "R6" : "R7";
    eqq.push_back(e);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; in_valid = 0; cmd_ready = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    #1;
    exp_valid = 0;
    chk(cmd_valid == 0, "R1", "cmd_valid after reset", cmd_valid, 0);
    chk(in_ready == 1, "R1", "in_ready after reset", in_ready, 1);
  endtask

  // mode 0: no gaps; 1: random gaps/stalls; 2: long consumer stalls
  task automatic run(input int mode);
    bit held = 0;
    logic [63:0] snap_id, snap_px;
    logic [31:0] snap_q;
    int t = 0;
    while ((bq.size() != 0 || eqq.size() != 0 || cmd_valid) && t < 20000) begin
      bit acc, lastb, nxt;
      @(negedge clk);
      t++; cycles++;
      case (mode)
        0: cmd_ready = 1;
        1: cmd_ready = ($urandom % 3) != 0;
        default: cmd_ready = (t % 24) >= 20;
      endcase
      in_valid = (bq.size() != 0) && (mode == 0 || ($urandom % 4) != 0);
      in_data  = (bq.size() != 0) ? bq[0] : 8'h00;
      #1;
      chk(cmd_valid == exp_valid, "R10", "cmd_valid timing", cmd_valid, exp_valid);
      chk(in_ready == !(cmd_valid && !cmd_ready), "R11", "in_ready", in_ready,
          !(cmd_valid && !cmd_ready));
      if (held && cmd_valid)
        chk(cmd_order_id == snap_id && cmd_price == snap_px && cmd_qty == snap_q,
            "R10", "held fields changed", cmd_order_id, snap_id);
      if (cmd_valid && cmd_ready) begin
        if (eqq.size() == 0) chk(0, "R3", "unexpected command", cmd_code, 0);
        else begin
          exp_t e = eqq.pop_front();
          chk(cmd_code == e.code[1:0], e.tag, "code", cmd_code, e.code);
          chk(cmd_side == e.side, e.tag, "side", cmd_side, e.side);
          chk(cmd_qty == e.qty, e.tag, "qty R8", cmd_qty, e.qty);
          chk(cmd_exec_qty == e.eq, e.tag, "exec qty", cmd_exec_qty, e.eq);
          chk(cmd_cancel_qty == e.cq, e.tag, "cancel qty", cmd_cancel_qty, e.cq);
          chk(cmd_price == e.px, e.tag, "price R8", cmd_price, e.px);
          chk(cmd_symbol == e.sym, "R9", "symbol", cmd_symbol, e.sym);
          chk(cmd_order_id == e.id, e.tag, "order id R8", cmd_order_id, e.id);
        end
      end
      held = cmd_valid && !cmd_ready;
      snap_id = cmd_order_id; snap_px = cmd_price; snap_q = cmd_qty;
      acc = in_valid && in_ready;
      lastb = acc ? lastq[0] : 1'b0;
      nxt = lastb || (cmd_valid && !cmd_ready);
      if (acc) begin void'(bq.pop_front()); void'(lastq.pop_front()); end
      exp_valid = nxt;
    end
    if (t >= 20000) chk(0, "R2", "watchdog expired", t, 0);
    chk(eqq.size() == 0, "R2", "commands outstanding", eqq.size(), 0);
  endtask

  initial begin
    do_reset();
    // R4, R5, R6, R7 back to back, no gaps
    add_msg(1, 64'h0102030405060708, 8'h42, 32'h11223344, "ABCDEF", 64'h0000_0012_3456_789A);
    add_msg(0, 64'hA1A2A3A4A5A6A7A8, 8'h53, 32'h0000BEEF, "XY    ", 64'h0000_0000_8765_4321);
    evt_msg(1, 64'h0102030405060708, 32'h00000064);
    evt_msg(0, 64'hA1A2A3A4A5A6A7A8, 32'hFFFF0001);
    run(0);
    // R3 unknown type skipped; R2 one-byte messages (length 0 and 1)
    put(8'd5, 0); put(8'h7F, 0); put(8'h21, 0); put(8'h22, 0); put(8'h23, 0);
    put(8'd0, 0); put(8'd1, 0);
    add_msg(0, 64'h5, 8'h42, 32'h00FF_0102, "QQQQQQ", 64'hFFFF_FFFF_0000_0010);
    run(0);
    // R10 / R11 under random gaps and stalls
    for (int i = 0; i < 6; i++) begin
      add_msg(i % 2, 64'h100 + i, (i % 3 == 0) ? 8'h42 : 8'h53, 32'h1000 * i + 7, "MNOPQR",
              64'h9000 + i);
      evt_msg(i % 2, 64'h100 + i, i + 1);
    end
    run(1);
    // R11 long stalls
    for (int i = 0; i < 3; i++) evt_msg(1, 64'h777 + i, 32'h55);
    add_msg(1, 64'hFEDCBA9876543210, 8'h53, 32'hCAFEF00D, "ZZZZZZ", 64'h8000_0000_0000_0001);
    run(2);
    // R1 reset in the middle of a message, then clean restart
    head(8'd33, 8'h21); put_le(64'h1234, 4);
    run(0);
    do_reset();
    evt_msg(0, 64'h42, 32'h9);
    run(0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule